// File: doc/BRIEF.md
# Prioritized Interrupt Controller Register File

This block collects interrupt requests from a parameterized set of sources and turns them into a single prioritized request toward a CPU. A rising edge on a source input sets that source's flag bit. The flag stays set until software clears it. A source is pending when both its flag bit and its enable bit are set. Each source also has a 5-bit priority field: a 3-bit level and a 2-bit sub-priority. Among the pending sources, the one with the highest level wins, and the sub-priority only breaks ties between sources at that level. The winner is raised to the CPU only when its level is strictly above the CPU's current-level input.

Software reaches the control, flag, enable and priority registers through a simple register bus. Every register can be written in three ways: a plain write replaces it, a set alias ORs ones into it, and a clear alias removes ones from it. A control bit selects how the request is reported. In single-vector mode every request carries the common vector 0. In multi-vector mode the vector is the source number.

The register bus has no back-pressure. It accepts one access per cycle, and read data returns on the following cycle. The request outputs are plain registered status pins with no handshake. They follow the register state with one cycle of latency.

Top module: `prio_intc`

## Requirements
- R1: Flag and enable bits are packed 32 sources to a word. Source n is bit n mod 32 of word n/32, and the number of words is NUM_SRC/32 rounded up. Bits of a word that do not map to a source read as 0 and ignore writes.
- R2: The address is {mode[1:0], region[1:0], index}. Mode 0 is a plain write, mode 1 clears the bits written as one, and mode 2 sets the bits written as one. Bits written as zero through mode 1 or 2 are unchanged. Mode 3 writes nothing. Region 0 is control, 1 is flags, 2 is enables and 3 is priorities. Reads return the register contents whatever the mode.
- R3: A source whose flag is set but whose enable bit is clear never becomes the reported source.
- R4: Priority word k holds sources 4k to 4k+3, one per byte, with source n in byte n mod 4. In each byte, bits [4:2] are the level and bits [1:0] are the sub-priority. Bits [7:5] always read 0.
- R5: A pending source with level 0 never raises irq_req.
- R6: Among pending sources the highest level wins. The sub-priority decides only between sources at that highest level.
- R7: When level and sub-priority are both equal, the lowest source number wins.
- R8: irq_req is raised only when the winner's level is strictly greater than cur_lvl.
- R9: A flag bit is set by a 0-to-1 change of its source input and stays set after the input falls. While the input is held high, no new edge occurs, so software can clear the flag.
- R10: When a source edge and a software clear of the same flag bit fall in the same cycle, the flag ends up set.
- R11: Control bit 0 selects multi-vector mode. When it is 0, irq_vec is 0. When it is 1 and a request is raised, irq_vec equals irq_src.
- R12: Reset clears all flag, enable, priority and control state, which selects single-vector mode.
- R13: Outputs are registered and follow the register state with one cycle of latency. While irq_req is 0, irq_src, irq_lvl and irq_vec are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Interrupt source inputs, edge-detected |
| cur_lvl | input | 3 | Current CPU level; a request must exceed it |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | IDX_W+4 | {mode, region, index} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_req | output | 1 | Request to the CPU |
| irq_src | output | SRC_W | Winning source number |
| irq_lvl | output | 3 | Winning source level |
| irq_vec | output | SRC_W | Reported vector (0 in single-vector mode) |

## Verification
A hardware edge on a source and a software clear-alias write to the same flag word can land in the same clock cycle. The bench provokes this by raising one source input on the same clock edge that a clear write targets both that source's bit and another bit that is already set. It then reads the flag word back and judges the result: the untouched bit must be cleared and the edge bit must be set. A second case holds a source high while clearing its flag, to show that a level alone does not re-arm the flag.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int LVL_W   = 3;
  localparam int SUB_W   = 2;
  localparam int FIELD_W = LVL_W + SUB_W;
  localparam int SRC_PER_PRIO = WORD_W / BYTE_W;

  typedef enum logic [1:0] {
    WM_PLAIN = 2'd0,
    WM_CLR   = 2'd1,
    WM_SET   = 2'd2,
    WM_NONE  = 2'd3
  } wr_mode_e;

  typedef enum logic [1:0] {
    RGN_CTRL = 2'd0,
    RGN_FLAG = 2'd1,
    RGN_EN   = 2'd2,
    RGN_PRIO = 2'd3
  } region_e;

  // New value of one storage bit under a write in the given mode
  function automatic logic mode_bit(logic cur, logic wbit, wr_mode_e m);
    case (m)
      WM_PLAIN: mode_bit = wbit;
      WM_CLR:   mode_bit = cur & ~wbit;
      WM_SET:   mode_bit = cur | wbit;
      default:  mode_bit = cur;
    endcase
  endfunction

endpackage

// File: rtl/ictl_bitbank.sv
module ictl_bitbank
  import ictl_pkg::*;
#(
  parameter int NUM_BITS = 40,
  parameter int IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    idx,
  input  wr_mode_e            wr_mode,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [NUM_BITS-1:0] hw_set,
  output logic [NUM_BITS-1:0] bits_q,
  output logic [WORD_W-1:0]   rd_word
);

  // Software update first, hardware set last: a set from hardware wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else begin
      for (int i = 0; i < NUM_BITS; i++) begin
        if (wr_en && (idx == IDX_W'(i / WORD_W)))
          bits_q[i] <= mode_bit(bits_q[i], wdata[i % WORD_W], wr_mode) | hw_set[i];
        else
          bits_q[i] <= bits_q[i] | hw_set[i];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_BITS; i++) begin
      if (idx == IDX_W'(i / WORD_W))
        rd_word[i % WORD_W] = bits_q[i];
    end
  end

endmodule

// File: rtl/ictl_prio_bank.sv
module ictl_prio_bank
  import ictl_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int IDX_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           idx,
  input  wr_mode_e                   wr_mode,
  input  logic [WORD_W-1:0]          wdata,
  output logic [NUM_SRC*FIELD_W-1:0] prio_q,
  output logic [WORD_W-1:0]          rd_word
);

  // Only the low FIELD_W bits of each byte are stored; the rest is dropped.
  logic wdata_unused;
  assign wdata_unused = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (idx == IDX_W'(i / SRC_PER_PRIO)) begin
          for (int j = 0; j < FIELD_W; j++) begin
            prio_q[i*FIELD_W + j] <= mode_bit(prio_q[i*FIELD_W + j],
                                              wdata[(i % SRC_PER_PRIO)*BYTE_W + j],
                                              wr_mode);
          end
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (idx == IDX_W'(i / SRC_PER_PRIO)) begin
        for (int j = 0; j < FIELD_W; j++)
          rd_word[(i % SRC_PER_PRIO)*BYTE_W + j] = prio_q[i*FIELD_W + j];
      end
    end
  end

endmodule

// File: rtl/ictl_arbiter.sv
module ictl_arbiter
  import ictl_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int SRC_W   = 6
) (
  input  logic [NUM_SRC-1:0]         pend,
  input  logic [NUM_SRC*FIELD_W-1:0] prio,
  input  logic [LVL_W-1:0]           cur_lvl,
  output logic                       win_req,
  output logic [SRC_W-1:0]           win_src,
  output logic [LVL_W-1:0]           win_lvl
);

  logic               found;
  logic [FIELD_W-1:0] best_key;
  logic [FIELD_W-1:0] key;

  // Ascending scan with a strict compare keeps the lowest index on a full tie.
  always_comb begin
    found    = 1'b0;
    best_key = '0;
    win_src  = '0;
    key      = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      key = prio[i*FIELD_W +: FIELD_W];
      if (pend[i] && (key[FIELD_W-1 -: LVL_W] != '0) && (!found || key > best_key)) begin
        found    = 1'b1;
        best_key = key;
        win_src  = SRC_W'(i);
      end
    end
    win_lvl = best_key[FIELD_W-1 -: LVL_W];
    win_req = found && (win_lvl > cur_lvl);
  end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import ictl_pkg::*;
#(
  parameter int NUM_SRC = 40,
  localparam int FLAG_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W,
  localparam int PRIO_WORDS = (NUM_SRC + SRC_PER_PRIO - 1) / SRC_PER_PRIO,
  localparam int IDX_W  = (PRIO_WORDS > 1) ? $clog2(PRIO_WORDS) : 1,
  localparam int ADDR_W = IDX_W + 4,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [2:0]         cur_lvl,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_req,
  output logic [SRC_W-1:0]   irq_src,
  output logic [2:0]         irq_lvl,
  output logic [SRC_W-1:0]   irq_vec
);

  // Address decode
  logic [IDX_W-1:0] a_idx;
  region_e          a_rgn;
  wr_mode_e         a_mode;
  logic             wr_any;

  assign a_idx  = bus_addr[IDX_W-1:0];
  assign a_rgn  = region_e'(bus_addr[IDX_W+1:IDX_W]);
  assign a_mode = wr_mode_e'(bus_addr[IDX_W+3:IDX_W+2]);
  assign wr_any = bus_sel && bus_wr;

  // Edge detection on sources
  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] src_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_in;
  end
  assign src_rise = src_in & ~src_q;

  // Control register: bit 0 selects multi-vector reporting
  logic mv_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mv_q <= 1'b0;
    else if (wr_any && a_rgn == RGN_CTRL && a_idx == '0)
      mv_q <= mode_bit(mv_q, bus_wdata[0], a_mode);
  end

  // Storage banks
  logic [NUM_SRC-1:0]         flag_q, en_q;
  logic [NUM_SRC*FIELD_W-1:0] prio_q;
  logic [WORD_W-1:0]          flag_rd, en_rd, prio_rd;

  ictl_bitbank #(.NUM_BITS(NUM_SRC), .IDX_W(IDX_W)) u_flag (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_any && a_rgn == RGN_FLAG), .idx(a_idx), .wr_mode(a_mode),
    .wdata(bus_wdata), .hw_set(src_rise),
    .bits_q(flag_q), .rd_word(flag_rd)
  );

  ictl_bitbank #(.NUM_BITS(NUM_SRC), .IDX_W(IDX_W)) u_en (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_any && a_rgn == RGN_EN), .idx(a_idx), .wr_mode(a_mode),
    .wdata(bus_wdata), .hw_set('0),
    .bits_q(en_q), .rd_word(en_rd)
  );

  ictl_prio_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_any && a_rgn == RGN_PRIO), .idx(a_idx), .wr_mode(a_mode),
    .wdata(bus_wdata), .prio_q(prio_q), .rd_word(prio_rd)
  );

  // Registered read data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      case (a_rgn)
        RGN_CTRL: bus_rdata <= (a_idx == '0) ? {31'b0, mv_q} : '0;
        RGN_FLAG: bus_rdata <= flag_rd;
        RGN_EN:   bus_rdata <= en_rd;
        default:  bus_rdata <= prio_rd;
      endcase
    end
  end

  // Arbitration and registered request outputs
  logic             win_req;
  logic [SRC_W-1:0] win_src;
  logic [LVL_W-1:0] win_lvl;

  ictl_arbiter #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
    .pend(flag_q & en_q), .prio(prio_q), .cur_lvl(cur_lvl),
    .win_req(win_req), .win_src(win_src), .win_lvl(win_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_src <= '0;
      irq_lvl <= '0;
      irq_vec <= '0;
    end else begin
      irq_req <= win_req;
      irq_src <= win_req ? win_src : '0;
      irq_lvl <= win_req ? win_lvl : '0;
      irq_vec <= (win_req && mv_q) ? win_src : '0;
    end
  end

  // Unused when FLAG_WORDS is only referenced for documentation of the map
  localparam int FLAG_WORDS_UNUSED = FLAG_WORDS;

endmodule

// File: rtl/prio_intc_checker.sv
module prio_intc_checker #(
  parameter int NUM_SRC = 40,
  parameter int SRC_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_in,
  input logic [NUM_SRC-1:0] src_q,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic               mv_q,
  input logic [2:0]         cur_lvl,
  input logic               irq_req,
  input logic [SRC_W-1:0]   irq_src,
  input logic [2:0]         irq_lvl,
  input logic [SRC_W-1:0]   irq_vec
);

  logic [NUM_SRC-1:0] pend_d;
  logic [2:0]         lvl_d;
  logic               mv_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_d <= '0;
      lvl_d  <= '0;
      mv_d   <= 1'b0;
    end else begin
      pend_d <= flag_q & en_q;
      lvl_d  <= cur_lvl;
      mv_d   <= mv_q;
    end
  end

  // R9 and R10: an edge always leaves the flag set, even against a clear
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_edge
    assert_edge_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (src_in[i] && !src_q[i]) |=> flag_q[i]);
  end

  assert_pending_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> pend_d[irq_src]);

  assert_above_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl > lvl_d));

  assert_level_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl != 3'd0));

  assert_single_vector_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mv_d |-> (irq_vec == '0));

  assert_idle_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_src == '0 && irq_lvl == 3'd0 && irq_vec == '0));

endmodule

bind prio_intc prio_intc_checker #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_q(src_q),
  .flag_q(flag_q), .en_q(en_q), .mv_q(mv_q), .cur_lvl(cur_lvl),
  .irq_req(irq_req), .irq_src(irq_src), .irq_lvl(irq_lvl), .irq_vec(irq_vec)
);

// File: tb/tb_prio_intc.sv
`timescale 1ns/1ps
module tb_prio_intc;

  localparam int N      = 40;
  localparam int IDX_W  = 4;
  localparam int ADDR_W = IDX_W + 4;
  localparam int SRC_W  = 6;
  localparam int PW     = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      src_in = '0;
  logic [2:0]        cur_lvl = '0;
  logic              bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              irq_req;
  logic [SRC_W-1:0]  irq_src, irq_vec;
  logic [2:0]        irq_lvl;

  always #2.5 clk = ~clk;

  prio_intc #(.NUM_SRC(N)) dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference state derived from the requirements
  logic [31:0] m_flag [2];
  logic [31:0] m_en   [2];
  logic [31:0] m_prio [PW];
  logic        m_mv;

  typedef struct { logic req; int src; int lvl; int vec; string tag; } exp_t;
  exp_t sb[$];

  function automatic logic [31:0] apply_mode(logic [31:0] w, int mode, logic [31:0] d);
    case (mode)
      0: return d;
      1: return w & ~d;
      2: return w | d;
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] flag_mask(int idx);
    return (idx == 0) ? 32'hFFFF_FFFF : 32'h0000_00FF;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic bus_write(int mode, int rgn, int idx, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_wdata = d;
    bus_addr = ADDR_W'((mode << (IDX_W+2)) | (rgn << IDX_W) | idx);
    case (rgn)
      0: if (idx == 0) m_mv = apply_mode({31'b0, m_mv}, mode, d) & 1;
      1: if (idx < 2) m_flag[idx] = apply_mode(m_flag[idx], mode, d) & flag_mask(idx);
      2: if (idx < 2) m_en[idx]   = apply_mode(m_en[idx], mode, d) & flag_mask(idx);
      default: if (idx < PW) m_prio[idx] = apply_mode(m_prio[idx], mode, d) & 32'h1F1F_1F1F;
    endcase
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(int rgn, int idx, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0;
    bus_addr = ADDR_W'((rgn << IDX_W) | idx);
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic read_check(string tag, int rgn, int idx, logic [31:0] exp);
    logic [31:0] d;
    bus_read(rgn, idx, d);
    check(tag, d, exp);
  endtask

  task automatic pulse_src(int i);
    @(negedge clk);
    src_in[i] = 1'b1;
    m_flag[i/32][i%32] = 1'b1;
    @(negedge clk);
    src_in[i] = 1'b0;
  endtask

  // Driver side of the scoreboard: predict and enqueue
  task automatic expect_irq(string tag);
    exp_t e;
    int best_f, best_i, f;
    bit found;
    repeat (3) @(negedge clk);
    found = 0; best_f = 0; best_i = 0;
    for (int i = 0; i < N; i++) begin
      f = int'((m_prio[i/4] >> ((i%4)*8)) & 32'h1F);
      if (m_flag[i/32][i%32] && m_en[i/32][i%32] && (f >> 2) != 0 && (!found || f > best_f)) begin
        found = 1; best_f = f; best_i = i;
      end
    end
    e.req = found && ((best_f >> 2) > int'(cur_lvl));
    e.src = e.req ? best_i : 0;
    e.lvl = e.req ? (best_f >> 2) : 0;
    e.vec = (e.req && m_mv) ? best_i : 0;
    e.tag = tag;
    sb.push_back(e);
    wait (sb.size() == 0);
  endtask

  // Monitor side: pop and compare away from the active edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check({e.tag, " req"}, 32'(irq_req), 32'(e.req));
        check({e.tag, " src"}, 32'(irq_src), 32'(e.src));
        check({e.tag, " lvl"}, 32'(irq_lvl), 32'(e.lvl));
        check({e.tag, " vec"}, 32'(irq_vec), 32'(e.vec));
      end
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_flag = '{default: '0}; m_en = '{default: '0};
    m_prio = '{default: '0}; m_mv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12: reset state
    read_check("R12 flag0", 1, 0, 0);
    read_check("R12 en0",   2, 0, 0);
    read_check("R12 prio0", 3, 0, 0);
    read_check("R12 ctrl",  0, 0, 0);
    expect_irq("R13 idle after reset");

    // R4: byte layout, upper bits of each byte read 0
    bus_write(0, 3, 1, 32'hFFFF_FFFF);
    read_check("R4 prio packing", 3, 1, 32'h1F1F_1F1F);
    bus_write(0, 3, 1, 32'h0);

    // R2: plain, set, clear aliases; zeros leave bits alone
    bus_write(0, 2, 0, 32'h0000_F0F0);
    bus_write(2, 2, 0, 32'h0000_000F);
    read_check("R2 set alias", 2, 0, 32'h0000_F0FF);
    bus_write(1, 2, 0, 32'h0000_00F0);
    read_check("R2 clear alias", 2, 0, 32'h0000_F00F);
    bus_write(2, 2, 0, 32'h0);
    bus_write(3, 2, 0, 32'hFFFF_FFFF);
    read_check("R2 zero and mode3 no change", 2, 0, 32'h0000_F00F);
    bus_write(0, 2, 0, 32'h0);

    // R1, R9: edges latch into the right word and bit, sticky
    pulse_src(3); pulse_src(35); pulse_src(39);
    read_check("R1 R9 flag word0", 1, 0, 32'h0000_0008);
    bus_write(2, 1, 1, 32'hFFFF_FF00);
    read_check("R1 flag word1 unmapped bits", 1, 1, 32'h0000_0088);

    // R9: held level gives no new edge after a clear
    @(negedge clk); src_in[5] = 1'b1; m_flag[0][5] = 1'b1;
    repeat (3) @(negedge clk);
    bus_write(1, 1, 0, 32'h0000_0020);
    repeat (2) @(negedge clk);
    read_check("R9 held level cleared", 1, 0, 32'h0000_0008);
    @(negedge clk); src_in[5] = 1'b0;
    bus_write(1, 1, 1, 32'h0000_0080);

    // R6: higher sub-priority wins at equal level
    bus_write(0, 3, 0, 32'h0800_0000);
    bus_write(0, 3, 8, 32'h0B00_0000);
    bus_write(2, 2, 0, 32'h0000_0008);
    bus_write(2, 2, 1, 32'h0000_0008);
    expect_irq("R6 sub-priority tie-break");

    // R7: full tie, lowest number
    bus_write(0, 3, 8, 32'h0800_0000);
    expect_irq("R7 lowest number on tie");

    // R3: higher level but not enabled
    pulse_src(10);
    bus_write(0, 3, 2, 32'h0014_0000);
    expect_irq("R3 disabled source ignored");
    bus_write(2, 2, 0, 32'h0000_0400);
    expect_irq("R6 higher level wins");

    // R8: strict comparison with cur_lvl
    @(negedge clk); cur_lvl = 3'd5;
    expect_irq("R8 equal level masked");
    @(negedge clk); cur_lvl = 3'd4;
    expect_irq("R8 lower current level");
    @(negedge clk); cur_lvl = 3'd0;

    // R11: vector reporting modes
    bus_write(2, 0, 0, 32'h1);
    read_check("R11 ctrl set", 0, 0, 32'h1);
    expect_irq("R11 multi-vector");
    bus_write(1, 0, 0, 32'h1);
    expect_irq("R11 single-vector");

    // R5: level 0 never requests
    bus_write(0, 2, 0, 32'h0); bus_write(0, 2, 1, 32'h0);
    pulse_src(20);
    bus_write(0, 3, 5, 32'h0000_0003);
    bus_write(2, 2, 0, 32'h0010_0000);
    expect_irq("R5 level zero");

    // R10: edge and clear of the same flag in one cycle
    @(negedge clk);
    src_in[7] = 1'b1;
    bus_sel = 1; bus_wr = 1; bus_wdata = 32'h0000_0088;
    bus_addr = ADDR_W'((1 << (IDX_W+2)) | (1 << IDX_W) | 0);
    m_flag[0] = (m_flag[0] & ~32'h88) | 32'h80;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; src_in[7] = 1'b0;
    read_check("R10 edge beats clear", 1, 0, m_flag[0]);

    // R13: all flags cleared gives idle outputs
    bus_write(0, 1, 0, 32'h0); bus_write(0, 1, 1, 32'h0);
    expect_irq("R13 idle after clear");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule